// File: doc/BRIEF.md
# Multiplexed 16-bit External Bus Controller

This controller links an 8-bit processor core to a slow external device of the disk-interface kind. On each data-move request it runs one bus cycle over two shared address/data ports and drives an address latch strobe. The low port carries address byte 0 and then data byte 0. The high port carries address byte 1 and then data byte 1.

A mode input selects the cycle type. In narrow mode every transfer moves one byte, and the high port holds the upper address for the whole cycle. In wide mode every transfer moves sixteen bits. The low byte comes from or returns to the core's accumulator path. The high byte comes from, or is captured into, a holding register that the core can load and read while the bus is quiet. A stretch input lengthens the read or write strobe for slow devices.

The upper address byte comes from the 16-bit pointer, or from the high port's own output latch. The latch is used when the address is an 8-bit indirect value, or when page access is in force.

The sequencer steps through five named states:
- ST_IDLE: waiting for a request.
- ST_ALE: the address latch strobe is high.
- ST_SETUP: one clock of data turnaround.
- ST_STROBE: 3 or 15 clocks with the read or write strobe low.
- ST_HOLD: one clock in which the strobe is released, write data is still driven and done pulses.

The transitions are:
- IDLE→ALE when a request is accepted.
- ALE→SETUP and SETUP→STROBE unconditionally.
- STROBE→STROBE until the strobe count is reached.
- STROBE→HOLD when the count is reached.
- HOLD→IDLE.

Top module: `xbus16_ctrl`

## Requirements
- R1: After reset the controller is idle. busy and done are 0, the ALE strobe is 0, both active-low strobes are 1, both port enables are 0, and the read-data and high-byte outputs are 0x00.
- R2: The ALE strobe is high for exactly the first clock of a cycle. In that clock both ports are enabled: the low port drives address bits 7:0 and the high port drives address bits 15:8.
- R3: The address comes from one of three sources:
  - When req_indirect_i=1, the low address byte is ind_addr_i and the high address byte is p2_latch_i.
  - When req_indirect_i=0 and page_dis_i=1, the high address byte is p2_latch_i.
  - Otherwise the address is ptr_addr_i.
- R4: With stretch_en_i=0 the strobe is low for 3 clocks and busy is high for 6 clocks.
- R5: With stretch_en_i=1 the strobe is low for 15 clocks and busy is high for 18 clocks.
- R6: On a write, the low port drives acc_wdata_i while the strobe is low. The high port drives the high-byte register in wide mode, and the high address byte in narrow mode.
- R7: On a wide read, both port enables are 0 while rd_n is low. acc_rdata_o takes p0_i and the high-byte register takes p2_i, both sampled on the last strobe clock.
- R8: On a narrow read, the high port keeps driving the high address byte and the high-byte register is unchanged. acc_rdata_o takes p0_i.
- R9: done is high for exactly one clock, the clock after the strobe rises, and busy falls after it.
- R10: On a write, the low port still drives the data in the clock after the strobe rises.
- R11: The high-byte register loads hb_wdata_i when hb_wr_i=1 while idle. Writes to it and new requests are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | active-low asynchronous reset |
| req_i | input | 1 | request a bus cycle (taken only when idle) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_indirect_i | input | 1 | 1 = 8-bit indirect address, 0 = 16-bit pointer |
| wide_en_i | input | 1 | 1 = 16-bit transfers |
| stretch_en_i | input | 1 | 1 = 15-clock strobe |
| page_dis_i | input | 1 | pointer high byte replaced by port latch |
| ptr_addr_i | input | 16 | 16-bit pointer address |
| ind_addr_i | input | 8 | 8-bit indirect address |
| p2_latch_i | input | 8 | high port output latch contents |
| acc_wdata_i | input | 8 | low write data byte |
| hb_wr_i | input | 1 | load the high-byte register |
| hb_wdata_i | input | 8 | value for the high-byte register |
| p0_i | input | 8 | low port pad input |
| p2_i | input | 8 | high port pad input |
| p0_o | output | 8 | low port drive value |
| p0_oe_o | output | 1 | low port drive enable |
| p2_o | output | 8 | high port drive value |
| p2_oe_o | output | 1 | high port drive enable |
| ale_o | output | 1 | address latch enable |
| rd_n_o | output | 1 | read strobe, active low |
| wr_n_o | output | 1 | write strobe, active low |
| busy_o | output | 1 | cycle in progress |
| done_o | output | 1 | one-clock end-of-cycle pulse |
| acc_rdata_o | output | 8 | low byte of last read |
| hb_rdata_o | output | 8 | high-byte register |

## Verification
A sequencer that sits in a wrong state shows up within one clock. The symptoms at the ports are:
- an ALE or strobe pulse of the wrong width;
- a busy window other than 6 or 18 clocks;
- port enables that stay on during a read strobe.

A wrong strobe count or a bad wide/narrow decode shows at the end of the cycle, in the captured read bytes or in the high-byte register. A bad address source shows in the ALE clock on the two port values.

// File: rtl/xbus16_pkg.sv
package xbus16_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD
    } bus_state_e;

    typedef struct packed {
        logic              is_write;
        logic              wide;
        logic              stretch;
        logic [BYTE_W-1:0] addr_lo;
        logic [BYTE_W-1:0] addr_hi;
        logic [BYTE_W-1:0] wdata_lo;
    } bus_req_t;
endpackage

// File: rtl/xbus16_addr_sel.sv
module xbus16_addr_sel
    import xbus16_pkg::*;
(
    input  logic              indirect_i,
    input  logic              page_dis_i,
    input  logic [2*BYTE_W-1:0] ptr_i,
    input  logic [BYTE_W-1:0] ind_i,
    input  logic [BYTE_W-1:0] latch_i,
    output logic [BYTE_W-1:0] lo_o,
    output logic [BYTE_W-1:0] hi_o
);
    always_comb begin
        lo_o = indirect_i ? ind_i : ptr_i[BYTE_W-1:0];
        hi_o = (indirect_i || page_dis_i) ? latch_i : ptr_i[2*BYTE_W-1:BYTE_W];
    end
endmodule

// File: rtl/xbus16_seq.sv
module xbus16_seq
    import xbus16_pkg::*;
#(
    parameter int SHORT_STROBE = 3,
    parameter int LONG_STROBE  = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       stretch_i,
    output bus_state_e state_o,
    output logic       strobe_last_o
);
    localparam int CNT_W = $clog2(LONG_STROBE + 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_STROBE - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_STROBE - 1);

    bus_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign last          = (state_q == ST_STROBE) &&
                           (cnt_q == (stretch_i ? LONG_LAST : SHORT_LAST));
    assign state_o       = state_q;
    assign strobe_last_o = last;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_ALE;
            ST_ALE:    state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_STROBE;
            ST_STROBE: if (last) state_d = ST_HOLD;
            ST_HOLD:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_STROBE) cnt_q <= cnt_q + 1'b1;
            else                      cnt_q <= '0;
        end
    end
endmodule

// File: rtl/xbus16_hi_reg.sv
module xbus16_hi_reg
    import xbus16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr_i,
    input  logic [BYTE_W-1:0] sw_data_i,
    input  logic              cap_i,
    input  logic [BYTE_W-1:0] cap_data_i,
    output logic [BYTE_W-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q_o <= '0;
        else if (cap_i)   q_o <= cap_data_i;
        else if (sw_wr_i) q_o <= sw_data_i;
    end
endmodule

// File: rtl/xbus16_ctrl.sv
module xbus16_ctrl
    import xbus16_pkg::*;
#(
    parameter int SHORT_STROBE = 3,
    parameter int LONG_STROBE  = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic        req_write_i,
    input  logic        req_indirect_i,
    input  logic        wide_en_i,
    input  logic        stretch_en_i,
    input  logic        page_dis_i,
    input  logic [15:0] ptr_addr_i,
    input  logic [7:0]  ind_addr_i,
    input  logic [7:0]  p2_latch_i,
    input  logic [7:0]  acc_wdata_i,
    input  logic        hb_wr_i,
    input  logic [7:0]  hb_wdata_i,
    input  logic [7:0]  p0_i,
    input  logic [7:0]  p2_i,
    output logic [7:0]  p0_o,
    output logic        p0_oe_o,
    output logic [7:0]  p2_o,
    output logic        p2_oe_o,
    output logic        ale_o,
    output logic        rd_n_o,
    output logic        wr_n_o,
    output logic        busy_o,
    output logic        done_o,
    output logic [7:0]  acc_rdata_o,
    output logic [7:0]  hb_rdata_o
);
    bus_state_e        state;
    logic              strobe_last;
    logic              start;
    logic              rd_capture;
    logic [BYTE_W-1:0] sel_lo, sel_hi;
    bus_req_t          cur_q;

    assign start = req_i && (state == ST_IDLE);

    xbus16_addr_sel u_addr (
        .indirect_i (req_indirect_i),
        .page_dis_i (page_dis_i),
        .ptr_i      (ptr_addr_i),
        .ind_i      (ind_addr_i),
        .latch_i    (p2_latch_i),
        .lo_o       (sel_lo),
        .hi_o       (sel_hi)
    );

    xbus16_seq #(
        .SHORT_STROBE (SHORT_STROBE),
        .LONG_STROBE  (LONG_STROBE)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .stretch_i     (cur_q.stretch),
        .state_o       (state),
        .strobe_last_o (strobe_last)
    );

    // request snapshot taken when a cycle is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (start) begin
            cur_q.is_write <= req_write_i;
            cur_q.wide     <= wide_en_i;
            cur_q.stretch  <= stretch_en_i;
            cur_q.addr_lo  <= sel_lo;
            cur_q.addr_hi  <= sel_hi;
            cur_q.wdata_lo <= acc_wdata_i;
        end
    end

    assign rd_capture = strobe_last && !cur_q.is_write;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          acc_rdata_o <= '0;
        else if (rd_capture) acc_rdata_o <= p0_i;
    end

    xbus16_hi_reg u_hi (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_wr_i    (hb_wr_i && (state == ST_IDLE)),
        .sw_data_i  (hb_wdata_i),
        .cap_i      (rd_capture && cur_q.wide),
        .cap_data_i (p2_i),
        .q_o        (hb_rdata_o)
    );

    // Moore outputs decoded from the sequencer state
    always_comb begin
        p0_o    = '0;
        p0_oe_o = 1'b0;
        p2_o    = '0;
        p2_oe_o = 1'b0;
        ale_o   = 1'b0;
        rd_n_o  = 1'b1;
        wr_n_o  = 1'b1;
        busy_o  = 1'b1;
        done_o  = 1'b0;
        unique case (state)
            ST_IDLE: busy_o = 1'b0;
            ST_ALE: begin
                ale_o   = 1'b1;
                p0_o    = cur_q.addr_lo;
                p0_oe_o = 1'b1;
                p2_o    = cur_q.addr_hi;
                p2_oe_o = 1'b1;
            end
            ST_SETUP, ST_STROBE, ST_HOLD: begin
                if (cur_q.is_write) begin
                    p0_o    = cur_q.wdata_lo;
                    p0_oe_o = 1'b1;
                end
                if (!cur_q.wide) begin
                    p2_o    = cur_q.addr_hi;
                    p2_oe_o = 1'b1;
                end else if (cur_q.is_write) begin
                    p2_o    = hb_rdata_o;
                    p2_oe_o = 1'b1;
                end
                if (state == ST_STROBE) begin
                    rd_n_o = cur_q.is_write;
                    wr_n_o = !cur_q.is_write;
                end
                done_o = (state == ST_HOLD);
            end
            default: busy_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/xbus16_chk.sv
module xbus16_chk #(
    parameter int SHORT_STROBE = 3,
    parameter int LONG_STROBE  = 15
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ale_o,
    input logic       rd_n_o,
    input logic       wr_n_o,
    input logic       p0_oe_o,
    input logic       p2_oe_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       hb_wr_i,
    input logic [7:0] hb_rdata_o
);
    localparam int CW = $clog2(LONG_STROBE + 2);
    logic [CW-1:0] stb_cnt;
    logic          stb_low;

    assign stb_low = !(rd_n_o && wr_n_o);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       stb_cnt <= '0;
        else if (stb_low) stb_cnt <= stb_cnt + 1'b1;
        else              stb_cnt <= '0;
    end

    // R2
    ale_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |-> (p0_oe_o && p2_oe_o && busy_o));

    // R2
    ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> !ale_o);

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_o && !wr_n_o));

    // R5
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stb_low) |-> (stb_cnt == CW'(SHORT_STROBE) || stb_cnt == CW'(LONG_STROBE)));

    // R7
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !p0_oe_o);

    // R9
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R11
    hb_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && hb_wr_i && rd_n_o) |=> $stable(hb_rdata_o));
endmodule

bind xbus16_ctrl xbus16_chk #(
    .SHORT_STROBE (SHORT_STROBE),
    .LONG_STROBE  (LONG_STROBE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ale_o      (ale_o),
    .rd_n_o     (rd_n_o),
    .wr_n_o     (wr_n_o),
    .p0_oe_o    (p0_oe_o),
    .p2_oe_o    (p2_oe_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .hb_wr_i    (hb_wr_i),
    .hb_rdata_o (hb_rdata_o)
);

// File: tb/tb_xbus16_ctrl.sv
module tb_xbus16_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_i = 0, req_write_i = 0, req_indirect_i = 0, wide_en_i = 0;
    logic stretch_en_i = 0, page_dis_i = 0, hb_wr_i = 0;
    logic [15:0] ptr_addr_i = '0;
    logic [7:0] ind_addr_i = '0, p2_latch_i = '0, acc_wdata_i = '0;
    logic [7:0] hb_wdata_i = '0, p0_i = '0, p2_i = '0;
    logic [7:0] p0_o, p2_o, acc_rdata_o, hb_rdata_o;
    logic p0_oe_o, p2_oe_o, ale_o, rd_n_o, wr_n_o, busy_o, done_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    xbus16_ctrl dut (.*);

    typedef struct packed {
        logic        wr, ind, wide, str, pdis;
        logic [15:0] ptr;
        logic [7:0]  iad, p2l, acc, hb, rlo, rhi;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h1234, 8'h00, 8'h5A, 8'hA5, 8'hC3, 8'h00, 8'h00},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'hBEEF, 8'h00, 8'h11, 8'h00, 8'h0D, 8'h3C, 8'h96},
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 8'h77, 8'h42, 8'h00, 8'h55, 8'h01, 8'hFE},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'h8001, 8'h00, 8'h66, 8'h99, 8'h24, 8'h00, 8'h00},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h4321, 8'h00, 8'h10, 8'h00, 8'h6B, 8'h5E, 8'h71},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'hCAFE, 8'h0F, 8'h20, 8'h81, 8'h33, 8'h00, 8'h00},
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'hFFFF, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 8'h00, 8'hAA, 8'h00, 8'h12, 8'hFF, 8'h00}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic hb_load(input logic [7:0] v);
        @(negedge clk);
        hb_wr_i = 1'b1;
        hb_wdata_i = v;
        @(negedge clk);
        hb_wr_i = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input logic [7:0] prev_rd);
        logic [7:0] exp_lo, exp_hi, a_lo, a_hi, s_p0, s_p2, h_p0;
        logic s_p0oe, s_p2oe, h_p0oe;
        int busy_n, ale_n, stb_n, done_n, done_at, stb_end;
        exp_lo = v.ind ? v.iad : v.ptr[7:0];
        exp_hi = (v.ind || v.pdis) ? v.p2l : v.ptr[15:8];
        busy_n = 0; ale_n = 0; stb_n = 0; done_n = 0; done_at = -1; stb_end = -1;
        a_lo = '0; a_hi = '0; s_p0 = '0; s_p2 = '0; h_p0 = '0;
        s_p0oe = 0; s_p2oe = 0; h_p0oe = 0;
        hb_load(v.hb);
        chk(hb_rdata_o == v.hb, "R11 hb load", hb_rdata_o, v.hb);
        @(negedge clk);
        req_i = 1'b1; req_write_i = v.wr; req_indirect_i = v.ind;
        wide_en_i = v.wide; stretch_en_i = v.str; page_dis_i = v.pdis;
        ptr_addr_i = v.ptr; ind_addr_i = v.iad; p2_latch_i = v.p2l;
        acc_wdata_i = v.acc; p0_i = v.rlo; p2_i = v.rhi;
        @(negedge clk);
        req_i = 1'b0;
        for (int n = 0; n < 40; n++) begin
            if (!busy_o) break;
            busy_n++;
            if (ale_o) begin
                ale_n++;
                if (n == 0) begin a_lo = p0_o; a_hi = p2_o; end
            end
            if (!rd_n_o || !wr_n_o) begin
                stb_n++;
                stb_end = n;
                if (stb_n == 1) begin
                    s_p0 = p0_o; s_p2 = p2_o; s_p0oe = p0_oe_o; s_p2oe = p2_oe_o;
                end
            end
            if (done_o) begin
                done_n++;
                done_at = n;
                h_p0 = p0_o; h_p0oe = p0_oe_o;
            end
            @(negedge clk);
        end
        chk(ale_n == 1, "R2 ale width", ale_n, 1);
        chk(a_lo == exp_lo, "R3 addr lo", a_lo, exp_lo);
        chk(a_hi == exp_hi, "R3 addr hi", a_hi, exp_hi);
        if (v.str) begin
            chk(stb_n == 15, "R5 strobe width", stb_n, 15);
            chk(busy_n == 18, "R5 cycle length", busy_n, 18);
        end else begin
            chk(stb_n == 3, "R4 strobe width", stb_n, 3);
            chk(busy_n == 6, "R4 cycle length", busy_n, 6);
        end
        chk(done_n == 1 && done_at == stb_end + 1, "R9 done pulse", done_at, stb_end + 1);
        if (v.wr) begin
            chk(s_p0oe && s_p0 == v.acc, "R6 low data", s_p0, v.acc);
            chk(s_p2oe && s_p2 == (v.wide ? v.hb : exp_hi), "R6 high data",
                s_p2, v.wide ? v.hb : exp_hi);
            chk(h_p0oe && h_p0 == v.acc, "R10 hold data", h_p0, v.acc);
            chk(acc_rdata_o == prev_rd, "R6 rdata kept", acc_rdata_o, prev_rd);
            chk(hb_rdata_o == v.hb, "R6 hb kept", hb_rdata_o, v.hb);
        end else if (v.wide) begin
            chk(!s_p0oe && !s_p2oe, "R7 ports released", {s_p0oe, s_p2oe}, 0);
            chk(acc_rdata_o == v.rlo, "R7 low capture", acc_rdata_o, v.rlo);
            chk(hb_rdata_o == v.rhi, "R7 high capture", hb_rdata_o, v.rhi);
        end else begin
            chk(!s_p0oe && s_p2oe && s_p2 == exp_hi, "R8 high addr held", s_p2, exp_hi);
            chk(acc_rdata_o == v.rlo, "R8 low capture", acc_rdata_o, v.rlo);
            chk(hb_rdata_o == v.hb, "R8 hb unchanged", hb_rdata_o, v.hb);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [7:0] last_rd;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy_o && !done_o && !ale_o, "R1 ctrl idle", {busy_o, done_o, ale_o}, 0);
        chk(rd_n_o && wr_n_o, "R1 strobes high", {rd_n_o, wr_n_o}, 3);
        chk(!p0_oe_o && !p2_oe_o, "R1 ports off", {p0_oe_o, p2_oe_o}, 0);
        chk(acc_rdata_o == 0 && hb_rdata_o == 0, "R1 regs zero", {acc_rdata_o, hb_rdata_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o, "R1 idle after release", busy_o, 0);

        last_rd = '0;
        for (int i = 0; i < 8; i++) begin
            run_vec(VECS[i], last_rd);
            if (!VECS[i].wr) last_rd = VECS[i].rlo;
        end

        // R11: writes and requests during a cycle are ignored
        hb_load(8'h5C);
        @(negedge clk);
        req_i = 1'b1; req_write_i = 1'b1; wide_en_i = 1'b1; stretch_en_i = 1'b0;
        req_indirect_i = 1'b0; page_dis_i = 1'b0; acc_wdata_i = 8'h3A;
        @(negedge clk);
        req_i = 1'b0;
        repeat (2) @(negedge clk);
        hb_wr_i = 1'b1; hb_wdata_i = 8'hE7; req_i = 1'b1;
        chk(busy_o && !wr_n_o && p2_o == 8'h5C, "R6 hb on port", p2_o, 8'h5C);
        @(negedge clk);
        hb_wr_i = 1'b0; req_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(!busy_o, "R11 busy request ignored", busy_o, 0);
        chk(hb_rdata_o == 8'h5C, "R11 busy write ignored", hb_rdata_o, 8'h5C);
        @(negedge clk);
        chk(!busy_o && !ale_o, "R11 no extra cycle", {busy_o, ale_o}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule